// File: doc/BRIEF.md
# Maskable Time-Date Alarm Comparator

This block holds five alarm registers, one for each of seconds, minutes, hours, day of month and month. It compares them with the current BCD time and date, which a separate timekeeping counter supplies. Bit 7 of every alarm register is an ignore bit: when it is 1 the field takes no part in the comparison. When every field that takes part equals the clock, the block raises an alarm flag. The flag can drive a level interrupt request and is cleared by a flag-register read pulse.

The comparison runs only on the cycle where the once-per-second update strobe is high. A time that stays equal to the alarm therefore sets the flag once, not on every clock. The seconds field must take part in the comparison for the alarm to fire, so the alarm fires at most once per minute. Alarm registers are written through a plain write strobe with a field select. A write takes effect only while a separate write-permit level is high; otherwise it is dropped. A combinational readback port returns the register chosen by a read select. The registers are volatile: reset fills each of them with its ignore bit set, and software must program them after power-up.

All ports are plain control and status pins. No data stream crosses the block, so it has no valid/ready handshake and never applies back-pressure.

Top module: `alarm_match_top`

## Requirements
- R1: After reset, the alarm flag is 0 and every alarm register reads back 0x80 (ignore bit set, value 0).
- R2: On a rising clock edge where `sec_tick_i` is 1, the flag becomes 1 from the next cycle on. This happens when the seconds field takes part in the comparison and every field that takes part has bits 6:0 equal to its time field. Field index 0 is seconds, 1 minutes, 2 hours, 3 day of month, 4 month. Time field k occupies bits 7k+6:7k of `now_time_i`. A mismatch in any field that takes part leaves the flag unchanged.
- R3: A 1 on `flag_rd_i` at a clock edge clears the flag from the next cycle on, unless R8 applies.
- R4: `irq_o` equals the alarm flag AND `irq_en_i` at all times, combinationally in `irq_en_i`.
- R5: A write stores `wr_data_i` into register `wr_sel_i` at the clock edge, and only when both `wr_stb_i` and `wr_allow_i` are 1. With `wr_allow_i` at 0 the register keeps its value.
- R6: While bit 7 of the seconds register is 1, the flag is never set, whatever the other fields hold.
- R7: On edges where `sec_tick_i` is 0 the flag is never set, even if the time equals the alarm.
- R8: If a set condition (R2) and a flag read happen on the same edge, the flag ends up 1.
- R9: Writes with `wr_sel_i` of 5 or more change no register. A read select of 5 or more returns 0.
- R10: `rd_data_o` combinationally shows the full 8-bit register chosen by `rd_sel_i`. A comparison on an edge uses the register values held before any write at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_stb_i | input | 1 | Alarm register write strobe |
| wr_allow_i | input | 1 | Write-permit level; writes are dropped while 0 |
| wr_sel_i | input | 3 | Field index of the write |
| wr_data_i | input | 8 | Write data: bit 7 ignore bit, bits 6:0 BCD value |
| rd_sel_i | input | 3 | Field index for readback |
| rd_data_o | output | 8 | Readback of the selected alarm register |
| now_time_i | input | 35 | Current time, five 7-bit BCD fields, seconds in the low bits |
| sec_tick_i | input | 1 | One-cycle strobe marking a new second |
| flag_rd_i | input | 1 | Flag-register read pulse, clears the flag |
| irq_en_i | input | 1 | Alarm interrupt enable |
| alarm_flag_o | output | 1 | Alarm flag |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that every input is a known value at each rising edge and that reset is held over at least one edge before use. They make no assumption about how often the tick strobe comes or whether the time fields are legal BCD, because the comparator treats them as plain bit patterns. The stimulus changes every input only at the falling clock edge. In the random phase it draws time and alarm values from a two-value set per field, so that full matches, partial matches, same-edge reads and writes to selects out of range all occur often.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
  localparam int unsigned ALM_FIELDS = 5;
  localparam int unsigned ALM_REG_W  = 8;
  localparam int unsigned ALM_VAL_W  = ALM_REG_W - 1;
  localparam int unsigned ALM_SEL_W  = $clog2(ALM_FIELDS);

  typedef enum logic [ALM_SEL_W-1:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_MDAY  = 3'd3,
    FLD_MONTH = 3'd4
  } alm_field_e;

  localparam logic [ALM_REG_W-1:0] ALM_RESET_VAL = {1'b1, {ALM_VAL_W{1'b0}}};
endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile #(
  parameter int unsigned N     = alarm_cmp_pkg::ALM_FIELDS,
  parameter int unsigned W     = alarm_cmp_pkg::ALM_REG_W,
  parameter int unsigned SEL_W = alarm_cmp_pkg::ALM_SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_stb_i,
  input  logic             wr_allow_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [W-1:0]     rd_data_o,
  output logic [N*W-1:0]   regs_o
);
  logic [W-1:0] reg_q [N];
  logic         wr_ok;
  logic         sel_bad;

  assign wr_ok   = wr_stb_i & wr_allow_i;
  assign sel_bad = ({1'b0, wr_sel_i} >= (SEL_W+1)'(N));

  for (genvar g = 0; g < N; g++) begin : g_reg
    logic we;
    assign we = wr_ok && (wr_sel_i == SEL_W'(g));

    always_ff @(posedge clk_i) begin
      if (!rst_ni)  reg_q[g] <= alarm_cmp_pkg::ALM_RESET_VAL;
      else if (we)  reg_q[g] <= wr_data_i;
    end

    assign regs_o[g*W +: W] = reg_q[g];

    // R5: a permitted write lands in the selected register
    p_store_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_stb_i && wr_allow_i && wr_sel_i == SEL_W'(g)) |=> (regs_o[g*W +: W] == $past(wr_data_i)));
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < N; i++) begin
      if (rd_sel_i == SEL_W'(i)) rd_data_o = reg_q[i];
    end
  end

  // R5: no permit, no change
  p_locked_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_stb_i && wr_allow_i) |=> $stable(regs_o));

  // R9: selects out of range leave every register alone
  p_badsel_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && sel_bad) |=> $stable(regs_o));
endmodule

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
  parameter int unsigned W = alarm_cmp_pkg::ALM_REG_W
) (
  input  logic [W-1:0] alarm_i,
  input  logic [W-2:0] now_i,
  output logic         hit_o
);
  logic ignore;
  assign ignore = alarm_i[W-1];
  assign hit_o  = ignore | (alarm_i[W-2:0] == now_i);
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic match_i,
  input  logic flag_rd_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;
  logic set_now;

  assign set_now = tick_i & match_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)        flag_q <= 1'b0;
    else if (set_now)   flag_q <= 1'b1;
    else if (flag_rd_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;

  // R2 / R8: a set on the strobe wins, read or not
  p_set_on_match_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && match_i) |=> flag_o);

  // R3: read without set clears
  p_read_clears_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_rd_i && !(tick_i && match_i)) |=> !flag_o);

  // R7: without the strobe the flag can only fall
  p_no_tick_no_set_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !flag_o) |=> !flag_o);

  // R4: a disabled interrupt never requests
  p_irq_gated_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o);
endmodule

// File: rtl/alarm_match_top.sv
module alarm_match_top #(
  parameter int unsigned N     = alarm_cmp_pkg::ALM_FIELDS,
  parameter int unsigned REG_W = alarm_cmp_pkg::ALM_REG_W,
  localparam int unsigned VAL_W = REG_W - 1,
  localparam int unsigned SEL_W = $clog2(N)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_stb_i,
  input  logic               wr_allow_i,
  input  logic [SEL_W-1:0]   wr_sel_i,
  input  logic [REG_W-1:0]   wr_data_i,
  input  logic [SEL_W-1:0]   rd_sel_i,
  output logic [REG_W-1:0]   rd_data_o,
  input  logic [N*VAL_W-1:0] now_time_i,
  input  logic               sec_tick_i,
  input  logic               flag_rd_i,
  input  logic               irq_en_i,
  output logic               alarm_flag_o,
  output logic               irq_o
);
  localparam int unsigned SEC_IDX = int'(alarm_cmp_pkg::FLD_SEC);

  logic [N*REG_W-1:0] regs;
  logic [N-1:0]       hit;
  logic               sec_ignored;
  logic               match;

  alarm_regfile #(.N(N), .W(REG_W), .SEL_W(SEL_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_stb_i   (wr_stb_i),
    .wr_allow_i (wr_allow_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .rd_sel_i   (rd_sel_i),
    .rd_data_o  (rd_data_o),
    .regs_o     (regs)
  );

  for (genvar g = 0; g < N; g++) begin : g_cmp
    alarm_field_cmp #(.W(REG_W)) u_cmp (
      .alarm_i (regs[g*REG_W +: REG_W]),
      .now_i   (now_time_i[g*VAL_W +: VAL_W]),
      .hit_o   (hit[g])
    );
  end

  assign sec_ignored = regs[SEC_IDX*REG_W + REG_W - 1];
  assign match       = (&hit) & ~sec_ignored;

  alarm_flag u_flag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (sec_tick_i),
    .match_i   (match),
    .flag_rd_i (flag_rd_i),
    .irq_en_i  (irq_en_i),
    .flag_o    (alarm_flag_o),
    .irq_o     (irq_o)
  );

  // R6: an ignored seconds field blocks every match
  p_sec_ignored_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_ignored && !alarm_flag_o) |=> !alarm_flag_o);

  // R1: flag is low on the cycle after reset
  p_reset_flag_r1 : assert property (@(posedge clk_i)
    !rst_ni |=> !alarm_flag_o);
endmodule

// File: tb/alarm_match_top_tb.sv
`timescale 1ns/1ps
module alarm_match_top_tb;
  localparam int NF = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0, wr_allow = 1'b0;
  logic [2:0]  wr_sel = '0, rd_sel = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic [6:0]  now_f [NF];
  logic [34:0] now_flat;
  logic        tick = 1'b0, flag_rd = 1'b0, irq_en = 1'b0;
  logic        flag, irq;

  int checks = 0, errors = 0;
  string tag = "R1";

  logic [7:0] m_reg [NF];
  bit         m_flag = 1'b0;

  always #2.5 clk = ~clk;

  assign now_flat = {now_f[4], now_f[3], now_f[2], now_f[1], now_f[0]};

  alarm_match_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_stb_i(wr_stb), .wr_allow_i(wr_allow),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .now_time_i(now_flat), .sec_tick_i(tick), .flag_rd_i(flag_rd),
    .irq_en_i(irq_en), .alarm_flag_o(flag), .irq_o(irq)
  );

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NF; i++) m_reg[i] = 8'h80;
      m_flag = 1'b0;
    end else begin
      bit hit;
      hit = (m_reg[0][7] == 1'b0);
      for (int i = 0; i < NF; i++)
        if (!m_reg[i][7] && m_reg[i][6:0] != now_f[i]) hit = 1'b0;
      if (tick && hit) m_flag = 1'b1;
      else if (flag_rd) m_flag = 1'b0;
      if (wr_stb && wr_allow && wr_sel < 3'd5) m_reg[wr_sel] = wr_data;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [2:0] s);
    return (s < 3'd5) ? m_reg[s] : 8'h00;
  endfunction

  // every cycle: compare against the model at the falling edge
  task automatic cyc();
    @(negedge clk);
    if (rst_n) begin
      chk(flag == m_flag, tag, flag, m_flag);
      chk(irq == (m_flag & irq_en), "R4", irq, m_flag & irq_en);
      chk(rd_data == exp_rd(rd_sel), "R10", rd_data, exp_rd(rd_sel));
    end
  endtask

  task automatic wr_reg(input logic [2:0] s, input logic [7:0] d);
    wr_stb = 1'b1; wr_sel = s; wr_data = d;
    cyc();
    wr_stb = 1'b0;
  endtask

  task automatic peek(input logic [2:0] s, input logic [7:0] e, input string req);
    rd_sel = s; #1;
    chk(rd_data == e, req, rd_data, e);
  endtask

  task automatic set_time(input logic [6:0] s, input logic [6:0] m, input logic [6:0] h,
                          input logic [6:0] d, input logic [6:0] mo);
    now_f[0] = s; now_f[1] = m; now_f[2] = h; now_f[3] = d; now_f[4] = mo;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    set_time(7'h00, 7'h00, 7'h00, 7'h01, 7'h01);
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1: reset state
    chk(flag == 1'b0, "R1", flag, 0);
    for (int i = 0; i < NF; i++) peek(3'(i), 8'h80, "R1");

    // R5: write without permit is dropped
    tag = "R5";
    wr_allow = 1'b0;
    wr_reg(3'd0, 8'h30);
    peek(3'd0, 8'h80, "R5");
    wr_allow = 1'b1;
    wr_reg(3'd0, 8'h30);
    wr_reg(3'd1, 8'h15);
    peek(3'd0, 8'h30, "R5");
    peek(3'd1, 8'h15, "R10");

    // R2: mismatch then match on the strobe
    tag = "R2";
    irq_en = 1'b1;
    set_time(7'h29, 7'h15, 7'h08, 7'h12, 7'h03);
    tick = 1'b1; cyc(); tick = 1'b0;
    chk(flag == 1'b0, "R2", flag, 0);
    set_time(7'h30, 7'h15, 7'h08, 7'h12, 7'h03);
    tick = 1'b1; cyc(); tick = 1'b0;
    chk(flag == 1'b1, "R2", flag, 1);
    chk(irq == 1'b1, "R4", irq, 1);
    irq_en = 1'b0; #1;
    chk(irq == 1'b0, "R4", irq, 0);
    irq_en = 1'b1;

    // R3: read clears
    tag = "R3";
    flag_rd = 1'b1; cyc(); flag_rd = 1'b0;
    chk(flag == 1'b0, "R3", flag, 0);

    // R7: matching time held, no strobe
    tag = "R7";
    repeat (6) cyc();
    chk(flag == 1'b0, "R7", flag, 0);

    // R8: set and read on one edge
    tag = "R8";
    tick = 1'b1; flag_rd = 1'b1; cyc(); tick = 1'b0; flag_rd = 1'b0;
    chk(flag == 1'b1, "R8", flag, 1);
    flag_rd = 1'b1; cyc(); flag_rd = 1'b0;

    // R6: seconds ignored blocks the alarm
    tag = "R6";
    wr_reg(3'd0, 8'hB0);
    tick = 1'b1; cyc(); tick = 1'b0;
    chk(flag == 1'b0, "R6", flag, 0);

    // R9: selects out of range
    tag = "R9";
    wr_reg(3'd5, 8'h11);
    wr_reg(3'd7, 8'h22);
    for (int i = 0; i < NF; i++) peek(3'(i), m_reg[i], "R9");
    peek(3'd5, 8'h00, "R9");
    peek(3'd6, 8'h00, "R9");

    // R2: hours take part and mismatch, then match
    tag = "R2";
    wr_reg(3'd0, 8'h30);
    wr_reg(3'd2, 8'h09);
    tick = 1'b1; cyc(); tick = 1'b0;
    chk(flag == 1'b0, "R2", flag, 0);
    now_f[2] = 7'h09;
    tick = 1'b1; cyc(); tick = 1'b0;
    chk(flag == 1'b1, "R2", flag, 1);

    // R10: write on the strobe edge is not used by that edge's compare
    tag = "R10";
    flag_rd = 1'b1; cyc(); flag_rd = 1'b0;
    tick = 1'b1; wr_stb = 1'b1; wr_sel = 3'd2; wr_data = 8'h05;
    cyc(); tick = 1'b0; wr_stb = 1'b0;
    chk(flag == 1'b1, "R10", flag, 1);

    // random phase
    tag = "R2";
    for (int n = 0; n < 4000; n++) begin
      wr_allow = ($urandom_range(0, 3) != 0);
      wr_stb   = ($urandom_range(0, 5) == 0);
      wr_sel   = 3'($urandom_range(0, 7));
      wr_data  = {($urandom_range(0, 3) == 0), 6'b0, 1'($urandom_range(0, 1))};
      for (int i = 0; i < NF; i++) now_f[i] = 7'($urandom_range(0, 1));
      tick     = ($urandom_range(0, 2) == 0);
      flag_rd  = ($urandom_range(0, 3) == 0);
      irq_en   = ($urandom_range(0, 1) == 1);
      rd_sel   = 3'($urandom_range(0, 7));
      cyc();
    end
    wr_stb = 1'b0; tick = 1'b0; flag_rd = 1'b0;
    cyc();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule